// File: doc/BRIEF.md
# Reset-Phase Power Watermark Emitter

This block sits around a functional core and turns the core's reset period into a signature broadcast. A circulating signature register drives a shift enable that decides, cycle by cycle, whether a 32-position rotating pattern register advances or holds. The switching activity of that rotation is the observable watermark. The same pattern register is the core's lookup storage. Once the core is running, shifting stops and the register is read combinationally through a core address.

When the external reset is released, the controller does not free the core straight away. It first keeps rotating the pattern register, one step per cycle, until the total rotation count returns to zero, so the lookup content is back in its home position. Only then does it drop the internal core reset. If the external reset was shorter than a parameterised minimum, the controller does not realign the register. It locks instead: the core stays in reset and the pattern stays frozen until the next external reset. A configuration-load input models the initial load of the storage. The pattern is loaded pre-rotated away from home, so the core cannot run without at least one proper reset. An optional hold factor stretches each signature bit over several clock cycles.

Top module: `wm_reset_emitter`

## Requirements
- R1: While `cfg_rst_n` is low, the storage is loaded. Afterwards `core_rst` is 1 and `wm_shift_en` is 0. The lookup reads `lut_out` at address a = HOME[(a + INIT_OFFSET) mod 32], which means the content starts rotated away from home.
- R2: During the external reset phase, the emission restarts at signature bit 31 (MSB first). In the i-th cycle of the phase, `wm_shift_en` equals SIGNATURE[31 - ((i / HOLD_M) mod 32)]. The emission repeats for as long as reset lasts.
- R3: At every rising edge where `wm_shift_en` is 1, the pattern rotates by one position (new[a] = old[a-1], new[0] = old[31]). At every other edge it holds.
- R4: After a reset that was long enough, `wm_shift_en` is 1 for exactly as many cycles as it takes for the net rotation to reach 0 mod 32. `core_rst` then falls in the following cycle.
- R5: While `core_rst` is 0, `wm_shift_en` is 0, the pattern does not move, and `lut_out` = HOME[core_addr], combinationally.
- R6: A release is honoured only if `ext_rst` was sampled high on at least MIN_RST consecutive rising edges. A shorter reset locks the block: `core_rst` stays 1, `wm_shift_en` stays 0, and the pattern is frozen in its misaligned position until `ext_rst` rises again.
- R7: With HOLD_M greater than 1, each signature bit is held on `wm_shift_en` for HOLD_M consecutive cycles.
- R8: `core_rst` is 1 whenever the net rotation count is nonzero.
- R9: Raising `ext_rst` from the run state or from the locked state starts a new emission at the MSB of the signature.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Operating clock |
| cfg_rst_n | input | 1 | Active-low storage load (configuration time) |
| ext_rst | input | 1 | Active-high external reset of the wrapped core |
| core_addr | input | 5 | Lookup address from the core |
| wm_shift_en | output | 1 | Pattern-register shift enable (watermark activity) |
| lut_out | output | 1 | Lookup result from the pattern register |
| core_rst | output | 1 | Internal reset released to the core |

## Verification
The emission is tried against reset pulses of several lengths: one cycle below the minimum, exactly the minimum, and well beyond it. The length one below the minimum separates a locked release from an honoured release at the exact boundary, and the long pulses show the signature wrapping around and repeating. Each release starts from a different rotation count, so the number of alignment cycles varies and the restored content is compared against the home image. A second instance with a hold factor of three shows whether the bit stretching follows the stated per-bit cadence. A short pulse from the run state shows that the content stays frozen and misaligned.

// File: rtl/wm_emit_pkg.sv
package wm_emit_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_EMIT   = 2'd1,
    ST_ALIGN  = 2'd2,
    ST_RUN    = 2'd3
  } wm_state_e;
endpackage

// File: rtl/wm_sig_source.sv
// Circulating signature register with per-bit hold counter.
module wm_sig_source #(
  parameter int               SIG_W     = 32,
  parameter int               HOLD_M    = 1,
  parameter logic [SIG_W-1:0] SIGNATURE = '0
) (
  input  logic clk,
  input  logic cfg_rst_n,
  input  logic restart,
  input  logic run,
  output logic bit_o
);
  localparam int HOLD_W = (HOLD_M > 1) ? $clog2(HOLD_M) : 1;
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_M - 1);

  logic [SIG_W-1:0]  sig_q;
  logic [HOLD_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!cfg_rst_n || restart) begin
      sig_q  <= SIGNATURE;
      hold_q <= '0;
    end else if (run) begin
      if (hold_q == HOLD_LAST) begin
        hold_q <= '0;
        sig_q  <= {sig_q[SIG_W-2:0], sig_q[SIG_W-1]};
      end else begin
        hold_q <= hold_q + 1'b1;
      end
    end
  end

  assign bit_o = sig_q[SIG_W-1];
endmodule

// File: rtl/wm_pattern_rot.sv
// Rotating pattern register built from chained sections; doubles as lookup storage.
module wm_pattern_rot #(
  parameter int SECT_W = 16,
  parameter int SECTS  = 2,
  parameter logic [SECT_W*SECTS-1:0] HOME = '0,
  parameter int OFFSET = 7,
  localparam int PAT_W = SECT_W * SECTS,
  localparam int POS_W = $clog2(PAT_W)
) (
  input  logic             clk,
  input  logic             cfg_rst_n,
  input  logic             shift,
  input  logic [POS_W-1:0] addr,
  output logic             lut_o,
  output logic [POS_W-1:0] pos_o,
  output logic             home_next_o,
  output logic [PAT_W-1:0] pat_o
);
  localparam int OFF_M = OFFSET % PAT_W;
  localparam logic [POS_W-1:0] POS_INIT = POS_W'((PAT_W - OFF_M) % PAT_W);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(PAT_W - 1);

  function automatic logic [PAT_W-1:0] rot_back(input logic [PAT_W-1:0] v, input int n);
    logic [PAT_W-1:0] r;
    for (int i = 0; i < PAT_W; i++) r[i] = v[(i + n) % PAT_W];
    return r;
  endfunction

  localparam logic [PAT_W-1:0] INIT_PAT = rot_back(HOME, OFF_M);

  logic [PAT_W-1:0] pat_flat;

  for (genvar s = 0; s < SECTS; s++) begin : g_sect
    localparam int PREV = (s + SECTS - 1) % SECTS;
    logic [SECT_W-1:0] q;
    logic              carry;
    assign carry = pat_flat[PREV*SECT_W + SECT_W - 1];
    always_ff @(posedge clk) begin
      if (!cfg_rst_n)  q <= INIT_PAT[s*SECT_W +: SECT_W];
      else if (shift)  q <= {q[SECT_W-2:0], carry};
    end
    assign pat_flat[s*SECT_W +: SECT_W] = q;
  end

  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (shift) pos_d = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!cfg_rst_n) pos_q <= POS_INIT;
    else            pos_q <= pos_d;
  end

  assign home_next_o = (pos_d == '0);
  assign pos_o       = pos_q;
  assign lut_o       = pat_flat[addr];
  assign pat_o       = pat_flat;
endmodule

// File: rtl/wm_ctrl.sv
// Reset-phase controller: emission, minimum-length check, realignment, lock.
module wm_ctrl
  import wm_emit_pkg::*;
#(
  parameter int MIN_RST = 40
) (
  input  logic      clk,
  input  logic      cfg_rst_n,
  input  logic      ext_rst,
  input  logic      sig_bit,
  input  logic      home_next,
  output wm_state_e state_o,
  output logic      shift_o,
  output logic      sig_restart_o,
  output logic      sig_run_o,
  output logic      core_rst_o
);
  localparam int LEN_W = $clog2(MIN_RST + 1);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_RST);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  wm_state_e        state_q, state_d;
  logic [LEN_W-1:0] len_q, len_d;

  always_comb begin
    state_d = state_q;
    len_d   = len_q;
    if (ext_rst) begin
      if (state_q != ST_EMIT) begin
        state_d = ST_EMIT;
        len_d   = LEN_ONE;
      end else if (len_q < LEN_MIN) begin
        len_d = len_q + 1'b1;
      end
    end else begin
      case (state_q)
        ST_EMIT:  state_d = (len_q >= LEN_MIN) ? (home_next ? ST_RUN : ST_ALIGN) : ST_LOCKED;
        ST_ALIGN: if (home_next) state_d = ST_RUN;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!cfg_rst_n) begin
      state_q <= ST_LOCKED;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
    end
  end

  assign shift_o       = ((state_q == ST_EMIT) && sig_bit) || (state_q == ST_ALIGN);
  assign sig_restart_o = ext_rst && (state_q != ST_EMIT);
  assign sig_run_o     = (state_q == ST_EMIT);
  assign core_rst_o    = (state_q != ST_RUN);
  assign state_o       = state_q;
endmodule

// File: rtl/wm_reset_emitter.sv
module wm_reset_emitter
  import wm_emit_pkg::*;
#(
  parameter int               SIG_W       = 32,
  parameter logic [SIG_W-1:0] SIGNATURE   = 32'hB38F_0E5A,
  parameter int               HOLD_M      = 1,
  parameter int               SECT_W      = 16,
  parameter int               SECTS       = 2,
  parameter logic [SECT_W*SECTS-1:0] HOME = 32'h6A3C_F190,
  parameter int               INIT_OFFSET = 7,
  parameter int               MIN_RST     = 40,
  localparam int PAT_W  = SECT_W * SECTS,
  localparam int ADDR_W = $clog2(PAT_W)
) (
  input  logic              clk,
  input  logic              cfg_rst_n,
  input  logic              ext_rst,
  input  logic [ADDR_W-1:0] core_addr,
  output logic              wm_shift_en,
  output logic              lut_out,
  output logic              core_rst
);
  wm_state_e         state_q;
  logic              sig_bit, sig_restart, sig_run, home_next;
  logic [ADDR_W-1:0] pos_q;
  logic [PAT_W-1:0]  pat_flat;

  wm_sig_source #(
    .SIG_W(SIG_W), .HOLD_M(HOLD_M), .SIGNATURE(SIGNATURE)
  ) u_sig (
    .clk(clk), .cfg_rst_n(cfg_rst_n), .restart(sig_restart),
    .run(sig_run), .bit_o(sig_bit)
  );

  wm_pattern_rot #(
    .SECT_W(SECT_W), .SECTS(SECTS), .HOME(HOME), .OFFSET(INIT_OFFSET)
  ) u_pat (
    .clk(clk), .cfg_rst_n(cfg_rst_n), .shift(wm_shift_en), .addr(core_addr),
    .lut_o(lut_out), .pos_o(pos_q), .home_next_o(home_next), .pat_o(pat_flat)
  );

  wm_ctrl #(.MIN_RST(MIN_RST)) u_ctrl (
    .clk(clk), .cfg_rst_n(cfg_rst_n), .ext_rst(ext_rst), .sig_bit(sig_bit),
    .home_next(home_next), .state_o(state_q), .shift_o(wm_shift_en),
    .sig_restart_o(sig_restart), .sig_run_o(sig_run), .core_rst_o(core_rst)
  );
endmodule

// File: rtl/wm_reset_emitter_chk.sv
module wm_reset_emitter_chk
  import wm_emit_pkg::*;
#(
  parameter int PAT_W = 32,
  parameter int POS_W = 5
) (
  input logic             clk,
  input logic             cfg_rst_n,
  input logic             ext_rst,
  input logic             wm_shift_en,
  input logic             core_rst,
  input logic [PAT_W-1:0] pat,
  input logic [POS_W-1:0] pos,
  input wm_state_e        state
);
  // R8
  off_home_hold_chk: assert property (@(posedge clk) disable iff (!cfg_rst_n)
    (pos != '0) |-> core_rst);

  // R3
  rot_step_chk: assert property (@(posedge clk) disable iff (!cfg_rst_n)
    wm_shift_en |=> (pat == {$past(pat[PAT_W-2:0]), $past(pat[PAT_W-1])}));

  // R3
  rot_hold_chk: assert property (@(posedge clk) disable iff (!cfg_rst_n)
    !wm_shift_en |=> $stable(pat));

  // R5
  run_quiet_chk: assert property (@(posedge clk) disable iff (!cfg_rst_n)
    !core_rst |-> !wm_shift_en);

  // R6
  lock_stay_chk: assert property (@(posedge clk) disable iff (!cfg_rst_n)
    (state == ST_LOCKED && !ext_rst) |=> (state == ST_LOCKED && core_rst));

  // R4
  release_home_chk: assert property (@(posedge clk) disable iff (!cfg_rst_n)
    $fell(core_rst) |-> (pos == '0));
endmodule

bind wm_reset_emitter wm_reset_emitter_chk #(.PAT_W(PAT_W), .POS_W(ADDR_W)) u_chk (
  .clk(clk), .cfg_rst_n(cfg_rst_n), .ext_rst(ext_rst), .wm_shift_en(wm_shift_en),
  .core_rst(core_rst), .pat(pat_flat), .pos(pos_q), .state(state_q)
);

// File: tb/wm_reset_emitter_bench.sv
`timescale 1ns/100ps
module wm_reset_emitter_bench;
  localparam logic [31:0] SIG  = 32'hB38F_0E5A;
  localparam logic [31:0] HOME = 32'h6A3C_F190;
  localparam int OFF = 7;
  localparam int MIN = 40;

  logic       clk = 1'b0;
  logic       cfg_rst_n = 1'b0;
  logic       ext_rst = 1'b0;
  logic [4:0] core_addr = '0;
  logic       wm_shift_en, lut_out, core_rst;
  logic       h_shift, h_lut, h_rst;

  int n_chk = 0;
  int n_bad = 0;
  int rot   = 0;

  always #5 clk = ~clk;

  wm_reset_emitter #(.SIGNATURE(SIG), .HOME(HOME), .INIT_OFFSET(OFF), .MIN_RST(MIN)) u_wm_reset_emitter (
    .clk(clk), .cfg_rst_n(cfg_rst_n), .ext_rst(ext_rst), .core_addr(core_addr),
    .wm_shift_en(wm_shift_en), .lut_out(lut_out), .core_rst(core_rst));

  wm_reset_emitter #(.SIGNATURE(SIG), .HOLD_M(3), .HOME(HOME), .INIT_OFFSET(OFF), .MIN_RST(MIN)) u_wm_reset_emitter_hold (
    .clk(clk), .cfg_rst_n(cfg_rst_n), .ext_rst(ext_rst), .core_addr(core_addr),
    .wm_shift_en(h_shift), .lut_out(h_lut), .core_rst(h_rst));

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_img(input int r);
    logic [31:0] img;
    for (int a = 0; a < 32; a++) img[a] = HOME[(a - r + 32) % 32];
    return img;
  endfunction

  // Called right after a negedge while the state is stable.
  task automatic read_all(output logic [31:0] img);
    for (int a = 0; a < 32; a++) begin
      core_addr = 5'(a);
      #0.1;
      img[a] = lut_out;
    end
  endtask

  task automatic t_config();
    logic [31:0] img;
    cfg_rst_n = 1'b0;
    ext_rst   = 1'b0;
    repeat (3) @(negedge clk);
    cfg_rst_n = 1'b1;
    @(negedge clk);
    rot = (32 - OFF) % 32;
    check(core_rst === 1'b1, "R1 core_rst after load", 32'(core_rst), 32'd1);
    check(wm_shift_en === 1'b0, "R1 shift_en after load", 32'(wm_shift_en), 32'd0);
    read_all(img);
    check(img === exp_img(rot), "R1 pre-rotated lookup image", img, exp_img(rot));
  endtask

  task automatic t_reset(input int n_high, input bit expect_run, input string tag);
    int seq_bad = 0, hold_bad = 0, rst_bad = 0, cnt = 0, need;
    logic [31:0] img;
    logic [31:0] first_bad = '0;
    @(negedge clk);
    ext_rst = 1'b1;
    for (int i = 0; i < n_high; i++) begin
      @(negedge clk);
      if (wm_shift_en !== SIG[31 - (i % 32)]) begin
        if (seq_bad == 0) first_bad = 32'(i);
        seq_bad++;
      end
      if (h_shift !== SIG[31 - ((i / 3) % 32)]) hold_bad++;
      if (core_rst !== 1'b1) rst_bad++;
      if (wm_shift_en === 1'b1) rot = (rot + 1) % 32;
    end
    ext_rst = 1'b0;
    check(seq_bad == 0, {"R2 R9 signature sequence, first bad cycle in got, ", tag}, first_bad, 32'd0);
    check(hold_bad == 0, {"R7 held-bit sequence mismatches, ", tag}, 32'(hold_bad), 32'd0);
    check(rst_bad == 0, {"R8 core_rst low during reset, ", tag}, 32'(rst_bad), 32'd0);
    if (expect_run) begin
      need = (32 - rot) % 32;
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        if (core_rst === 1'b0) break;
        cnt++;
      end
      check(cnt == need, {"R4 alignment cycles, ", tag}, 32'(cnt), 32'(need));
      rot = 0;
      read_all(img);
      check(img === HOME, {"R4 R5 home image after release, ", tag}, img, HOME);
    end else begin
      int bad = 0;
      repeat (20) begin
        @(negedge clk);
        if (core_rst !== 1'b1 || wm_shift_en !== 1'b0) bad++;
      end
      check(bad == 0, {"R6 locked outputs, ", tag}, 32'(bad), 32'd0);
      read_all(img);
      check(img === exp_img(rot), {"R6 frozen image, ", tag}, img, exp_img(rot));
    end
  endtask

  task automatic t_run_idle();
    int bad = 0;
    logic [31:0] img;
    repeat (50) begin
      @(negedge clk);
      if (wm_shift_en !== 1'b0 || core_rst !== 1'b0) bad++;
    end
    check(bad == 0, "R5 run state quiet", 32'(bad), 32'd0);
    read_all(img);
    check(img === HOME, "R5 lookup stable in run", img, HOME);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_config();
    t_reset(MIN - 1, 1'b0, "one below minimum (R6)");
    t_reset(70, 1'b1, "long from locked (R9)");
    t_run_idle();
    t_reset(MIN, 1'b1, "exact minimum from run (R6 R9)");
    t_reset(5, 1'b0, "short from run (R6)");
    t_reset(100, 1'b1, "wrapping long reset (R2)");
    t_run_idle();
    finish_run();
  end
endmodule